// File: doc/BRIEF.md
# Banked GPIO Port with Atomic Set and Clear

This block is a memory-mapped general purpose I/O port built from banks of 32 pins. Software programs each pin as an input or an output, drives outputs through a data register, and reads back the synchronized level of every pad. Output bits can be changed without a read-modify-write. One word sets the bits that are 1 in the written mask. Another word clears them. Bits that are 0 in the mask keep their value.

The port sits on a plain 32-bit register bus with a byte address, a write enable, write data and read data. A write takes effect at the clock edge where the enable is sampled high. A read is combinational from the address and is valid in the same cycle. The bus carries no stream, so it has no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented.

Each pin has three pad signals: the level from the pad, the level to drive, and an output enable. The input level passes through a two-stage synchronizer before software can read it. A pin that drives its own pad therefore reads back its driven level two cycles after the pad changes.

Top module: `gpio_banked_port`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0, direction reads all ones) and the output data is all zeros (pad_out all 0).
- R2: Bank b occupies byte addresses from 0x10 + 0x28*b onward. Within a bank the word offsets are: direction 0x00, output data 0x04, set alias 0x08, clear alias 0x0C, input data 0x10.
- R3: A direction bit of 1 makes its pin an input (pad_oe bit 0). A direction bit of 0 makes it an output (pad_oe bit 1).
- R4: A write to the output data word replaces all 32 output bits. pad_out shows the new value after the write edge, and pad_out and pad_oe never change without a write.
- R5: A write to the set alias drives to 1 each output bit whose mask bit is 1 and leaves every other bit unchanged.
- R6: A write to the clear alias drives to 0 each output bit whose mask bit is 1 and leaves every other bit unchanged.
- R7: Reads of the set alias and the clear alias return the current output data.
- R8: The input data word returns the pad level of every pin of the bank, including output pins, as sampled two clock edges earlier.
- R9: Words at bank offsets 0x14 through 0x24 read as zero and ignore writes.
- R10: Addresses below 0x10, addresses beyond the last bank, and addresses not aligned to 4 bytes read as zero and ignore writes.
- R11: bus_rdata follows bus_addr in the same cycle, and a written value is readable in the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32*NUM_BANKS (64) | Level seen on each pad |
| pad_out | output | 32*NUM_BANKS (64) | Level driven on each pad |
| pad_oe | output | 32*NUM_BANKS (64) | Drive enable for each pad, 1 = drive |

## Verification
The bench targets the set and clear aliases with masks that overlap bits already at the target value. A design that treated the mask as new data would corrupt the unmasked bits. It checks the input word one and two edges after a pad change. A design with one stage too few or too many would show the new level a cycle early or late. It also checks input readback on pins that are driven as outputs, where a design that looped the output register back would ignore the pad. Writes go to the unused words of a bank, below the first bank, past the last bank and to misaligned addresses. A decoder that folded these onto real registers would change the direction or output data, which the bench sees at the pads.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BANK_PINS       = 32;
  localparam int BANK_BASE_BYTE  = 16;
  localparam int WORDS_PER_BANK  = 10;
  localparam int BANK_STRIDE     = 4 * WORDS_PER_BANK;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BIDX_W-1:0] bank,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:0] word_ofs;
  logic [ADDR_W-1:0] bank_num;
  logic [ADDR_W-1:0] word_in_bank;

  // word index counted from the first bank window
  assign word_ofs     = (addr - ADDR_W'(BANK_BASE_BYTE)) >> 2;
  assign bank_num     = word_ofs / ADDR_W'(WORDS_PER_BANK);
  assign word_in_bank = word_ofs % ADDR_W'(WORDS_PER_BANK);

  always_comb begin
    hit  = 1'b0;
    bank = '0;
    sel  = SEL_NONE;
    if (addr[1:0] == 2'b00 && addr >= ADDR_W'(BANK_BASE_BYTE) &&
        bank_num < ADDR_W'(NUM_BANKS)) begin
      bank = bank_num[BIDX_W-1:0];
      case (word_in_bank)
        ADDR_W'(0): sel = SEL_DIR;
        ADDR_W'(1): sel = SEL_OUT;
        ADDR_W'(2): sel = SEL_SET;
        ADDR_W'(3): sel = SEL_CLR;
        ADDR_W'(4): sel = SEL_IN;
        default:    sel = SEL_NONE;
      endcase
      hit = (sel != SEL_NONE);
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int PINS        = BANK_PINS,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_sel_e        sel,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] in_q
);
  logic [PINS-1:0] sync_stg [SYNC_STAGES];

  // direction and output data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR: dir_q <= wdata;
        SEL_OUT: out_q <= wdata;
        SEL_SET: out_q <= out_q | wdata;
        SEL_CLR: out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  // pad synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_stg[i] <= '0;
    end else begin
      sync_stg[0] <= pad_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_stg[i] <= sync_stg[i-1];
    end
  end

  assign in_q = sync_stg[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_banked_port.sv
module gpio_banked_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = BANK_PINS * NUM_BANKS,
  localparam int BIDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [BANK_PINS-1:0] bus_wdata,
  output logic [BANK_PINS-1:0] bus_rdata,
  input  logic [PINS-1:0]      pad_in,
  output logic [PINS-1:0]      pad_out,
  output logic [PINS-1:0]      pad_oe
);
  logic              dec_hit;
  logic [BIDX_W-1:0] dec_bank;
  reg_sel_e          dec_sel;

  logic [BANK_PINS-1:0] dir_w [NUM_BANKS];
  logic [BANK_PINS-1:0] out_w [NUM_BANKS];
  logic [BANK_PINS-1:0] in_w  [NUM_BANKS];

  gpio_win_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .bank (dec_bank),
    .sel  (dec_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = bus_we && dec_hit && (dec_bank == BIDX_W'(b));

    gpio_bank #(
      .PINS        (BANK_PINS),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_we),
      .sel    (dec_sel),
      .wdata  (bus_wdata),
      .pad_in (pad_in[b*BANK_PINS +: BANK_PINS]),
      .dir_q  (dir_w[b]),
      .out_q  (out_w[b]),
      .in_q   (in_w[b])
    );

    assign pad_out[b*BANK_PINS +: BANK_PINS] = out_w[b];
    assign pad_oe [b*BANK_PINS +: BANK_PINS] = ~dir_w[b];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (dec_hit) begin
      case (dec_sel)
        SEL_DIR:                   bus_rdata = dir_w[dec_bank];
        SEL_OUT, SEL_SET, SEL_CLR: bus_rdata = out_w[dec_bank];
        SEL_IN:                    bus_rdata = in_w[dec_bank];
        default:                   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_banked_port_chk.sv
module gpio_banked_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = BANK_PINS * NUM_BANKS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [BANK_PINS-1:0] bus_wdata,
  input logic [BANK_PINS-1:0] bus_rdata,
  input logic [PINS-1:0]      pad_in,
  input logic [PINS-1:0]      pad_out,
  input logic [PINS-1:0]      pad_oe
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (pad_oe == '0 && pad_out == '0));

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  p_low_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(BANK_BASE_BYTE)) |-> (bus_rdata == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam int BA = BANK_BASE_BYTE + BANK_STRIDE * b;

    p_set_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(BA + 8)) |=>
        ((pad_out[b*BANK_PINS +: BANK_PINS] & $past(bus_wdata)) == $past(bus_wdata)));

    p_set_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(BA + 8)) |=>
        ((pad_out[b*BANK_PINS +: BANK_PINS] & ~$past(bus_wdata)) ==
         ($past(pad_out[b*BANK_PINS +: BANK_PINS]) & ~$past(bus_wdata))));

    p_clr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(BA + 12)) |=>
        ((pad_out[b*BANK_PINS +: BANK_PINS] & $past(bus_wdata)) == '0));

    if (SYNC_STAGES == 2) begin : g_lag
      p_in_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && bus_addr == ADDR_W'(BA + 16)) |->
          (bus_rdata == $past(pad_in[b*BANK_PINS +: BANK_PINS], 2)));
    end
  end
endmodule

bind gpio_banked_port gpio_banked_port_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .ADDR_W      (ADDR_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_gpio_banked_port.sv
`timescale 1ns/1ps
module sim_gpio_banked_port;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [63:0] pin = '0;
  logic [63:0] pout, poe;

  logic [31:0] dir_m [NB];
  logic [31:0] out_m [NB];
  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gpio_banked_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rd), .pad_in(pin),
    .pad_out(pout), .pad_oe(poe)
  );

  // decode per R2, R9, R10: returns bank in b, word in k, valid flag
  function automatic bit map_addr(input logic [7:0] a, output int b, output int k);
    int w;
    b = 0; k = 0;
    if (a[1:0] != 2'b00 || a < 8'h10) return 0;
    w = (int'(a) - 16) / 4;
    b = w / 10;
    k = w % 10;
    return (b < NB);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int b, k;
    if (!map_addr(a, b, k)) return '0;
    case (k)
      0: return dir_m[b];
      1, 2, 3: return out_m[b];
      4: return pin[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int b, k;
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    if (map_addr(a, b, k)) begin
      case (k)
        0: dir_m[b] = d;
        1: out_m[b] = d;
        2: out_m[b] = out_m[b] | d;
        3: out_m[b] = out_m[b] & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    @(negedge clk); addr = a;
    #1 check(tag, {32'h0, rd}, {32'h0, exp_read(a)});
  endtask

  task automatic pads_chk(input string tag);
    #1;
    check({tag, " pad_out"}, pout, {out_m[1], out_m[0]});
    check({tag, " pad_oe"}, poe, ~{dir_m[1], dir_m[0]});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin dir_m[b] = '1; out_m[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    pads_chk("R1 reset");
    rd_chk(8'h10, "R1 dir bank0");
    rd_chk(8'h38, "R1 dir bank1");

    // R3 direction
    wr(8'h10, 32'h0000_FFFF);
    pads_chk("R3 dir bank0");
    rd_chk(8'h10, "R3 read dir");

    // R4 full replace, bank1 via R2 window
    wr(8'h14, 32'hA5A5_0F0F);
    pads_chk("R4 out bank0");
    wr(8'h3C, 32'h1234_5678);
    pads_chk("R4 out bank1");
    rd_chk(8'h3C, "R11 out readback");

    // R5 set with overlapping mask
    wr(8'h18, 32'h0000_FFF0);
    pads_chk("R5 set bank0");
    rd_chk(8'h18, "R7 set alias read");

    // R6 clear with overlapping mask
    wr(8'h44, 32'hFF00_00F8);
    pads_chk("R6 clr bank1");
    rd_chk(8'h44, "R7 clr alias read");

    // R8 two-edge lag on an output pin bank (bank0 partly output)
    @(negedge clk); addr = 8'h20; pin = 64'h0000_0000_CAFE_0001;
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1 check("R8 in settled", {32'h0, rd}, 64'h0000_0000_CAFE_0001);
    pin = 64'h0000_0000_1357_9BDF;
    @(negedge clk); #1 check("R8 one edge old", {32'h0, rd}, 64'h0000_0000_CAFE_0001);
    @(negedge clk); #1 check("R8 two edges new", {32'h0, rd}, 64'h0000_0000_1357_9BDF);

    // R9 unused words
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0000_0000);
    rd_chk(8'h24, "R9 unused word read");
    rd_chk(8'h5C, "R9 unused word bank1");
    pads_chk("R9 unused write");

    // R10 outside and misaligned
    wr(8'h0C, 32'h0);
    wr(8'h60, 32'h0);
    wr(8'h11, 32'h0);
    wr(8'h15, 32'hFFFF_FFFF);
    pads_chk("R10 outside write");
    rd_chk(8'h04, "R10 below read");
    rd_chk(8'h60, "R10 beyond read");
    rd_chk(8'h11, "R10 misaligned read");

    // R2 random mix over the map
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      @(negedge clk); pin = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0)
        a = 8'(16 + 40 * $urandom_range(0, NB - 1) + 4 * $urandom_range(0, 9));
      else
        a = 8'($urandom_range(0, 255));
      wr(a, $urandom);
      @(negedge clk);
      rd_chk(a, "R2 random same addr");
      rd_chk(8'(16 + 40 * $urandom_range(0, NB - 1) + 4 * $urandom_range(0, 4)), "R2 random reg");
      pads_chk("R2 random pads");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule